// File: doc/BRIEF.md
# Cycle Counter Profiling Event Generator

This block keeps a free-running cycle counter and derives timing events from it for a trace or profiling subsystem. A selectable counter bit is watched for toggles. Each toggle steps a reloadable 4-bit down-counter, called the post-scaler. When the post-scaler is at zero, a toggle fires either a program-counter sample request or a cycle-count event, and the post-scaler reloads. A second group of selectable high-order counter bits paces periodic synchronisation requests.

Four independent 8-bit profiling counters sit beside the cycle counter. Each one advances on its own per-cycle qualifier strobe: interrupt overhead, extra instruction cycles, load/store cycles and sleep cycles. A counter emits a pulse each time it wraps. Every output is a registered pulse one cycle wide, and the downstream logic turns these pulses into packets.

The host programs the block through a simple write port. Address 0 is control, address 1 the cycle counter, address 2 the post-scaler, and addresses 3 to 6 the profiling counters 0 to 3. Address 7 is unused and writes to it are ignored.

Top module: `cyc_prof_evgen`

## Requirements
- R1: After synchronous reset, all event outputs are 0, `cyc_count` is 0 and every control field is 0.
- R2: The cycle counter advances by one per clock while the run bit (control bit 0) is 1, and holds while it is 0. A write to address 1 loads `wr_data` and takes priority over counting in that cycle.
- R3: Tap select (control bit 1) chooses which cycle-counter bit paces the post-scaler: 0 selects bit TAP_LO and 1 selects bit TAP_HI. A tap event is any change of the selected bit caused by counting.
- R4: On each tap event the post-scaler fires if it is at 0 and then reloads from the preset (control bits 5:2); otherwise it decrements. A preset of 0 fires on every tap event, and a preset of N fires once per N+1 tap events. The post-scaler is 0 after reset or after a write of 0 to address 2.
- R5: A firing raises `pc_sample_evt` when PC-sample enable (control bit 8) is 1. Otherwise it raises `cyc_cnt_evt` when cycle-event enable (control bit 9) is 1. The two outputs are never high together, and with both enables at 0 a firing produces no output.
- R6: Sync select (control bits 7:6) picks the sync tap: 00 off, 01 bit SYNC_A, 10 bit SYNC_B, 11 bit SYNC_C. Each change of the selected bit caused by counting raises `sync_req` for one cycle.
- R7: No sync request and no post-scaler event occurs while the run bit is 0.
- R8: Profiling counter i (0 interrupt overhead, 1 extra instruction cycles, 2 load/store, 3 sleep) counts its strobe from the value last written to address 3+i. It raises `prof_evt[i]` on the step that wraps it from 255 to 0.
- R9: A wrap of profiling counter i produces no pulse while its event enable (control bit 10+i) is 0.
- R10: The load/store counter (index 2) does not count the first cycle of each run of consecutive strobe cycles, so a 4-cycle operation adds 3.
- R11: Every event output is a pulse one cycle wide. It is visible in the same cycle as the counter value that caused it: a tap-bit-6-style event appears when `cyc_count` first shows 2^TAP_LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| prof_strobe | input | 4 | Per-cycle qualifiers for the profiling counters |
| cyc_count | output | CNT_W | Current cycle counter value |
| pc_sample_evt | output | 1 | PC sample request pulse |
| cyc_cnt_evt | output | 1 | Cycle-count event pulse |
| sync_req | output | 1 | Synchronisation request pulse |
| prof_evt | output | 4 | Profiling counter wrap pulses |

## Verification
The bench builds the block with a 12-bit cycle counter, post-scaler taps at bits 2 and 4, and sync taps at bits 5, 6 and 7. These shrink the event periods from 64, 1024 and 16M+ cycles to 4, 16, 32, 64 and 128 cycles. With those periods, every sync select code, both tap choices and several post-scaler presets can be counted exactly within a few hundred cycles. The profiling counters keep their full 8-bit width, and preloading them near 255 brings each wrap and the load/store first-cycle rule within a handful of strobes.

// File: rtl/cyc_prof_pkg.sv
package cyc_prof_pkg;
  localparam int NPROF = 4;
  localparam int PS_W  = 4;
  localparam int AW    = 3;

  typedef struct packed {
    logic [NPROF-1:0] prof_evt_en;
    logic             cyc_evt_en;
    logic             pc_smp_en;
    logic [1:0]       sync_sel;
    logic [PS_W-1:0]  reload;
    logic             tap_sel;
    logic             run;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [AW-1:0] A_CTL   = 3'd0;
  localparam logic [AW-1:0] A_CYC   = 3'd1;
  localparam logic [AW-1:0] A_POST  = 3'd2;
  localparam int            A_PROF0 = 3;
endpackage

// File: rtl/cpc_cycle_core.sv
module cpc_cycle_core #(
  parameter int CNT_W  = 32,
  parameter int TAP_LO = 6,
  parameter int TAP_HI = 10,
  parameter int SYNC_A = 24,
  parameter int SYNC_B = 26,
  parameter int SYNC_C = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tap_sel,
  input  logic [1:0]       sync_sel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             sync_req
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, flips;
  logic             adv, sync_hit, sync_q;

  assign cnt_nxt = cnt_q + 1'b1;
  assign flips   = cnt_q ^ cnt_nxt;
  assign adv     = run && !load;
  assign tick    = adv && (tap_sel ? flips[TAP_HI] : flips[TAP_LO]);

  always_comb begin
    case (sync_sel)
      2'b01:   sync_hit = flips[SYNC_A];
      2'b10:   sync_hit = flips[SYNC_B];
      2'b11:   sync_hit = flips[SYNC_C];
      default: sync_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      if (load)     cnt_q <= load_val;
      else if (run) cnt_q <= cnt_nxt;
      sync_q <= adv && sync_hit;
    end
  end

  assign cnt      = cnt_q;
  assign sync_req = sync_q;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));
  // R7
  sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> ($past(run) && $past(sync_sel) != 2'b00));
endmodule

// File: rtl/cpc_post_scaler.sv
module cpc_post_scaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            load,
  input  logic [PS_W-1:0] load_val,
  input  logic [PS_W-1:0] reload,
  input  logic            pc_en,
  input  logic            cyc_en,
  output logic            pc_evt,
  output logic            cyc_evt
);
  logic [PS_W-1:0] post_q;
  logic            fire, pc_q, cyc_q;

  assign fire = tick && !load && (post_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q <= '0;
      pc_q   <= 1'b0;
      cyc_q  <= 1'b0;
    end else begin
      if (load)      post_q <= load_val;
      else if (tick) post_q <= (post_q == '0) ? reload : post_q - 1'b1;
      pc_q  <= fire && pc_en;
      cyc_q <= fire && !pc_en && cyc_en;
    end
  end

  assign pc_evt  = pc_q;
  assign cyc_evt = cyc_q;

  // R5
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_q && cyc_q));
  // R4
  fire_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_q || cyc_q) |-> ($past(post_q) == '0 && $past(tick)));
endmodule

// File: rtl/cpc_prof_ctr.sv
module cpc_prof_ctr #(
  parameter int W          = 8,
  parameter bit SKIP_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         evt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         evt
);
  logic [W-1:0] cnt_q;
  logic         strobe_d, inc, evt_q;

  assign inc = strobe && (!SKIP_FIRST || strobe_d) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_d <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      strobe_d <= strobe;
      if (load)     cnt_q <= load_val;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      evt_q <= inc && evt_en && (cnt_q == '1);
    end
  end

  assign evt = evt_q;

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> (cnt_q == '0));
  // R9
  wrap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(evt_en));
endmodule

// File: rtl/cyc_prof_evgen.sv
module cyc_prof_evgen
  import cyc_prof_pkg::*;
#(
  parameter int          CNT_W     = 32,
  parameter int          DATA_W    = 32,
  parameter int          PROF_W    = 8,
  parameter int          TAP_LO    = 6,
  parameter int          TAP_HI    = 10,
  parameter int          SYNC_A    = 24,
  parameter int          SYNC_B    = 26,
  parameter int          SYNC_C    = 28,
  parameter logic [3:0]  SKIP_MASK = 4'b0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        prof_strobe,
  output logic [CNT_W-1:0]  cyc_count,
  output logic              pc_sample_evt,
  output logic              cyc_cnt_evt,
  output logic              sync_req,
  output logic [3:0]        prof_evt
);
  ctl_t ctl_q;
  logic tick;
  logic wr_ctl, wr_cyc, wr_post;

  assign wr_ctl  = wr_en && (wr_addr == A_CTL);
  assign wr_cyc  = wr_en && (wr_addr == A_CYC);
  assign wr_post = wr_en && (wr_addr == A_POST);

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
  end

  cpc_cycle_core #(
    .CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI),
    .SYNC_A(SYNC_A), .SYNC_B(SYNC_B), .SYNC_C(SYNC_C)
  ) u_core (
    .clk(clk), .rst(rst), .run(ctl_q.run), .tap_sel(ctl_q.tap_sel),
    .sync_sel(ctl_q.sync_sel), .load(wr_cyc), .load_val(wr_data[CNT_W-1:0]),
    .cnt(cyc_count), .tick(tick), .sync_req(sync_req)
  );

  cpc_post_scaler #(.PS_W(PS_W)) u_post (
    .clk(clk), .rst(rst), .tick(tick), .load(wr_post),
    .load_val(wr_data[PS_W-1:0]), .reload(ctl_q.reload),
    .pc_en(ctl_q.pc_smp_en), .cyc_en(ctl_q.cyc_evt_en),
    .pc_evt(pc_sample_evt), .cyc_evt(cyc_cnt_evt)
  );

  for (genvar i = 0; i < NPROF; i++) begin : g_prof
    logic ld;
    assign ld = wr_en && (wr_addr == AW'(A_PROF0 + i));
    cpc_prof_ctr #(.W(PROF_W), .SKIP_FIRST(SKIP_MASK[i])) u_ctr (
      .clk(clk), .rst(rst), .strobe(prof_strobe[i]),
      .evt_en(ctl_q.prof_evt_en[i]), .load(ld),
      .load_val(wr_data[PROF_W-1:0]), .evt(prof_evt[i])
    );
  end

  // R7
  no_run_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_sample_evt || cyc_cnt_evt) |-> $past(ctl_q.run));
  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> !sync_req);
endmodule

// File: tb/cyc_prof_evgen_test.sv
module cyc_prof_evgen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  prof_strobe = '0;
  logic [11:0] cyc_count;
  logic        pc_sample_evt, cyc_cnt_evt, sync_req;
  logic [3:0]  prof_evt;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  cyc_prof_evgen #(
    .CNT_W(12), .DATA_W(32), .PROF_W(8), .TAP_LO(2), .TAP_HI(4),
    .SYNC_A(5), .SYNC_B(6), .SYNC_C(7), .SKIP_MASK(4'b0100)
  ) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prof_strobe(prof_strobe), .cyc_count(cyc_count),
    .pc_sample_evt(pc_sample_evt), .cyc_cnt_evt(cyc_cnt_evt),
    .sync_req(sync_req), .prof_evt(prof_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 32'(data);
    tick();
    wr_en = 1'b0;
  endtask

  function automatic int mk(int run, int tap, int rl, int sy, int pc, int cy, int pen);
    return run | (tap << 1) | (rl << 2) | (sy << 6) | (pc << 8) | (cy << 9) | (pen << 10);
  endfunction

  task automatic setup(input int ctl);
    wr(0, ctl & ~1);
    wr(1, 0);
    wr(2, 0);
    wr(0, ctl);
  endtask

  task automatic count_evts(input int n, output int pc, output int cy, output int sy);
    pc = 0; cy = 0; sy = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (pc_sample_evt) pc++;
      if (cyc_cnt_evt) cy++;
      if (sync_req) sy++;
    end
  endtask

  task automatic t_reset();
    chk(cyc_count == 0, "R1 count", cyc_count, 0);
    chk({pc_sample_evt, cyc_cnt_evt, sync_req, prof_evt} == 0, "R1 events",
        {pc_sample_evt, cyc_cnt_evt, sync_req, prof_evt}, 0);
  endtask

  task automatic t_counter();
    int pc, cy, sy;
    setup(mk(1, 0, 0, 0, 0, 0, 0));
    count_evts(10, pc, cy, sy);
    chk(cyc_count == 10, "R2 run", cyc_count, 10);
    wr(1, 100);
    chk(cyc_count == 100, "R2 load", cyc_count, 100);
    tick();
    chk(cyc_count == 101, "R2 after load", cyc_count, 101);
    wr(0, 0);
    count_evts(5, pc, cy, sy);
    chk(cyc_count == 102, "R2 hold", cyc_count, 102);
  endtask

  task automatic t_timing();
    setup(mk(1, 0, 0, 0, 1, 0, 0));
    tick(); tick(); tick();
    chk(pc_sample_evt == 0, "R11 before tap", pc_sample_evt, 0);
    tick();
    chk(pc_sample_evt == 1 && cyc_count == 4, "R11 at tap", pc_sample_evt, 1);
    tick();
    chk(pc_sample_evt == 0, "R11 one cycle", pc_sample_evt, 0);
  endtask

  task automatic t_post();
    int pc, cy, sy;
    setup(mk(1, 0, 0, 0, 1, 0, 0));
    count_evts(64, pc, cy, sy);
    chk(pc == 16, "R4 preset 0", pc, 16);
    setup(mk(1, 0, 2, 0, 1, 0, 0));
    count_evts(96, pc, cy, sy);
    chk(pc == 8, "R4 preset 2", pc, 8);
    setup(mk(1, 1, 0, 0, 1, 0, 0));
    count_evts(64, pc, cy, sy);
    chk(pc == 4, "R3 high tap", pc, 4);
  endtask

  task automatic t_prec();
    int pc, cy, sy;
    setup(mk(1, 0, 0, 0, 1, 1, 0));
    count_evts(64, pc, cy, sy);
    chk(pc == 16 && cy == 0, "R5 pc wins", cy, 0);
    setup(mk(1, 0, 0, 0, 0, 1, 0));
    count_evts(64, pc, cy, sy);
    chk(cy == 16 && pc == 0, "R5 cyc only", cy, 16);
    setup(mk(1, 0, 0, 0, 0, 0, 0));
    count_evts(64, pc, cy, sy);
    chk(cy + pc == 0, "R5 none", cy + pc, 0);
  endtask

  task automatic t_sync();
    int pc, cy, sy;
    setup(mk(1, 0, 0, 1, 0, 0, 0));
    count_evts(128, pc, cy, sy);
    chk(sy == 4, "R6 sel 01", sy, 4);
    setup(mk(1, 0, 0, 2, 0, 0, 0));
    count_evts(128, pc, cy, sy);
    chk(sy == 2, "R6 sel 10", sy, 2);
    setup(mk(1, 0, 0, 3, 0, 0, 0));
    count_evts(128, pc, cy, sy);
    chk(sy == 1, "R6 sel 11", sy, 1);
    setup(mk(1, 0, 0, 0, 0, 0, 0));
    count_evts(128, pc, cy, sy);
    chk(sy == 0, "R6 sel 00", sy, 0);
    setup(mk(0, 0, 0, 1, 1, 0, 0));
    count_evts(128, pc, cy, sy);
    chk(sy == 0 && pc == 0 && cyc_count == 0, "R7 stopped", sy + pc, 0);
  endtask

  task automatic t_prof();
    int seen;
    wr(0, mk(0, 0, 0, 0, 0, 0, 4'b0001));
    wr(3, 250);
    prof_strobe = 4'b0001;
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      if (prof_evt[0]) seen++;
    end
    chk(seen == 0, "R8 no early wrap", seen, 0);
    tick();
    chk(prof_evt[0] == 1, "R8 wrap", prof_evt[0], 1);
    prof_strobe = 4'b0000;
    tick();
    chk(prof_evt[0] == 0, "R11 prof pulse", prof_evt[0], 0);
    wr(0, mk(0, 0, 0, 0, 0, 0, 4'b0001));
    wr(4, 255);
    prof_strobe = 4'b0010;
    tick();
    prof_strobe = 4'b0000;
    chk(prof_evt[1] == 0, "R9 disabled", prof_evt[1], 0);
  endtask

  task automatic t_lsu();
    int seen;
    wr(0, mk(0, 0, 0, 0, 0, 0, 4'b0100));
    wr(5, 252);
    prof_strobe = 4'b0100;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (prof_evt[2]) seen++;
    end
    prof_strobe = 4'b0000;
    tick();
    chk(seen == 0, "R10 four cycles add three", seen, 0);
    prof_strobe = 4'b0100;
    tick();
    chk(prof_evt[2] == 0, "R10 first skipped", prof_evt[2], 0);
    tick();
    chk(prof_evt[2] == 1, "R10 wrap", prof_evt[2], 1);
    prof_strobe = 4'b0000;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_counter();
    t_timing();
    t_post();
    t_prec();
    t_sync();
    t_prof();
    t_lsu();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule